// File: doc/BRIEF.md
# Serial-In Parallel-Out Shift Register with Storage Latch

This block collects a serial bit stream into a shift stage and, on a separate clock, copies the whole shift stage into a storage register that drives the parallel outputs. Because the two stages have independent clocks, a new word can be shifted in while the previous word stays steady on the outputs. When the storage clock fires, all outputs change together.

An active-low asynchronous clear empties the shift stage only. The latched word on the outputs stays as it was. An active-low output enable gates the parallel drivers: when it is off, the outputs float and a flag reports that they are not driven. The top bit of the shift stage leaves the block on a cascade pin that is always driven. Wiring that pin to the serial input of a second block makes one longer register.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `shift_clk` with `clear_n` high, shift bit 0 takes `ser_in` and each bit k (0 to 6) moves into bit k+1.
- R2: On each rising edge of `store_clk`, the storage register takes all eight shift bits at once, and `par_out[k]` shows storage bit k while driven.
- R3: While `clear_n` is low, the shift stage is zero with no clock edge needed, `shift_clk` edges have no effect, and the storage register keeps its value.
- R4: `ser_out` always equals shift bit 7. It stays driven whatever `oe_n` is, and it reads 0 while `clear_n` is low.
- R5: With `oe_n` high, `par_drive` is 0 and `par_out` floats. With `oe_n` low, `par_drive` is 1 and `par_out` drives the storage register.
- R6: When `shift_clk` and `store_clk` rise on the same edge, the storage register takes the shift value from before that edge.
- R7: `oe_n` has no effect on either register. A word latched or shifted while the outputs float appears unchanged once they are enabled again.
- R8: When two blocks are chained from `ser_out` to `ser_in`, 16 shifts followed by one store leave the later 8 bits in the first block and the earlier 8 bits in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift stage clock, rising edge |
| store_clk | input | 1 | Storage register clock, rising edge |
| clear_n | input | 1 | Asynchronous clear of the shift stage, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| ser_in | input | 1 | Serial data into shift bit 0 |
| par_out | output | WIDTH | Storage register contents, or high impedance when disabled |
| par_drive | output | 1 | High while `par_out` is driven |
| ser_out | output | 1 | Cascade output, shift bit WIDTH-1 |

## Verification
A wrong shift stage shows up on `ser_out` as soon as the bad bit reaches the top position, which takes up to seven shifts. It appears on `par_out` only after the next storage pulse, so the bench stores often and checks the cascade pin after every shift. A storage register that is wrong, or that a clear reaches, shows at once on the enabled outputs. A gating fault shows when the outputs are enabled again after a disabled stretch and the word has changed.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int SIPO_DEF_W = 8;

  // index of the cascade tap for a given register width
  function automatic int tap_index(input int w);
    return w - 1;
  endfunction
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int WIDTH = sipo_pkg::SIPO_DEF_W
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             din,
  output logic [WIDTH-1:0] q,
  output logic             tap
);
  localparam int TAP = sipo_pkg::tap_index(WIDTH);

  // next shift value: new bit enters at position 0
  function automatic logic [WIDTH-1:0] push_bit(input logic [WIDTH-1:0] cur,
                                                input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) q <= '0;
    else          q <= push_bit(q, din);
  end

  assign tap = q[TAP];
endmodule

// File: rtl/sipo_hold_stage.sv
module sipo_hold_stage #(
  parameter int WIDTH = sipo_pkg::SIPO_DEF_W
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // no reset: contents are undefined until the first storage pulse
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/sipo_out_drive.sv
module sipo_out_drive #(
  parameter int WIDTH = sipo_pkg::SIPO_DEF_W
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] pins,
  output logic             drive
);
  assign drive = ~oe_n;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pins[i] = drive ? d[i] : 1'bz;
  end
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
  parameter int WIDTH = sipo_pkg::SIPO_DEF_W
) (
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             clear_n,
  input  logic             oe_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] par_out,
  output logic             par_drive,
  output logic             ser_out
);
  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] st_q;

  sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk(shift_clk), .clear_n(clear_n), .din(ser_in), .q(sh_q), .tap(ser_out)
  );

  sipo_hold_stage #(.WIDTH(WIDTH)) u_hold (
    .clk(store_clk), .d(sh_q), .q(st_q)
  );

  sipo_out_drive #(.WIDTH(WIDTH)) u_drv (
    .oe_n(oe_n), .d(st_q), .pins(par_out), .drive(par_drive)
  );
endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
  parameter int WIDTH = sipo_pkg::SIPO_DEF_W
) (
  input logic             shift_clk,
  input logic             store_clk,
  input logic             clear_n,
  input logic             oe_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_out,
  input logic             par_drive,
  input logic             ser_out,
  input logic [WIDTH-1:0] sh_q,
  input logic [WIDTH-1:0] st_q
);
  logic [WIDTH-1:0] snap;
  logic             seen = 1'b0;

  always @(posedge store_clk) begin
    snap <= sh_q;
    seen <= 1'b1;
  end

  // R1
  shift_move_chk: assert property (@(posedge shift_clk) disable iff (!clear_n)
    1'b1 |=> sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

  // R2, R6
  always @(negedge store_clk) begin
    if (seen) begin
      store_load_chk: assert (st_q == snap);
    end
  end

  // R3
  clear_zero_chk: assert property (@(posedge shift_clk)
    !clear_n |-> (sh_q == '0 && ser_out == 1'b0));

  // R4
  cascade_tap_chk: assert property (@(posedge shift_clk) disable iff (!clear_n)
    1'b1 |=> ser_out == $past(sh_q[WIDTH-2]));

  // R5
  drive_match_chk: assert property (@(posedge shift_clk) disable iff (!clear_n)
    !oe_n |-> (par_drive && par_out == st_q));

  // R5
  float_flag_chk: assert property (@(posedge shift_clk) disable iff (!clear_n)
    oe_n |-> !par_drive);
endmodule

bind sipo_latch_reg sipo_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n),
  .oe_n(oe_n), .ser_in(ser_in), .par_out(par_out), .par_drive(par_drive),
  .ser_out(ser_out), .sh_q(sh_q), .st_q(st_q)
);

// File: tb/sim_sipo_latch_reg.sv
`timescale 1ns/1ps
module sim_sipo_latch_reg;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic shift_clk = 1'b0, store_clk = 1'b0, clear_n = 1'b0, oe_n = 1'b1, ser_in = 1'b0;
  logic [7:0] out0, out1;
  logic drv0, drv1, so0, so1;

  sipo_latch_reg #(.WIDTH(8)) u0 (
    .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n), .oe_n(oe_n),
    .ser_in(ser_in), .par_out(out0), .par_drive(drv0), .ser_out(so0)
  );
  sipo_latch_reg #(.WIDTH(8)) u1 (
    .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n), .oe_n(oe_n),
    .ser_in(so0), .par_out(out1), .par_drive(drv1), .ser_out(so1)
  );

  int checks = 0, failures = 0;
  logic done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one step: set data, optional clock pulses, sample after outputs settle
  task automatic step(input logic ser, input logic sh, input logic st, input logic oe);
    @(negedge clk);
    ser_in = ser;
    oe_n = oe;
    @(posedge clk);
    #1;
    shift_clk = sh;
    store_clk = st;
    @(negedge clk);
    shift_clk = 1'b0;
    store_clk = 1'b0;
    #1;
  endtask

  // {ser, shift, store, oe_n, expected par_out[7:0], expected drive, expected ser_out}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {4'b1100, 8'h00, 1'b1, 1'b0},  // R1
    {4'b0100, 8'h00, 1'b1, 1'b0},  // R1
    {4'b1100, 8'h00, 1'b1, 1'b0},  // R1
    {4'b1100, 8'h00, 1'b1, 1'b0},  // R1 shift=0B
    {4'b0010, 8'h0B, 1'b1, 1'b0},  // R2
    {4'b1110, 8'h0B, 1'b1, 1'b0},  // R6 shift=17, store keeps old 0B
    {4'b0011, 8'h00, 1'b0, 1'b0},  // R5 R7 store 17 while floating
    {4'b0000, 8'h17, 1'b1, 1'b0},  // R7 word visible after enable
    {4'b0100, 8'h17, 1'b1, 1'b0},  // R1 2E
    {4'b0100, 8'h17, 1'b1, 1'b0},  // R1 5C
    {4'b0100, 8'h17, 1'b1, 1'b1},  // R4 B8, top bit out
    {4'b1100, 8'h17, 1'b1, 1'b0},  // R4 71
    {4'b0010, 8'h71, 1'b1, 1'b0}   // R2
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // power-up: clear shift stage, then one store to define outputs
    repeat (2) @(posedge clk);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    clear_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 reset par_out", {24'd0, out0}, 32'h00);
    chk("R3 reset ser_out", {31'd0, so0}, 32'h0);
    chk("R5 reset drive", {31'd0, drv0}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      step(v[13], v[12], v[11], v[10]);
      chk($sformatf("R1/R2/R5/R6/R7 vec%0d drive", i), {31'd0, drv0}, {31'd0, v[1]});
      if (v[1]) chk($sformatf("R2 vec%0d par_out", i), {24'd0, out0}, {24'd0, v[9:2]});
      chk($sformatf("R4 vec%0d ser_out", i), {31'd0, so0}, {31'd0, v[0]});
    end

    // R7: shifts while floating leave the latched word alone
    step(1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 latched word after float", {24'd0, out0}, 32'h71);

    // fill shift stage with ones (8 more shifts), top bit high
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R4 ser_out with outputs floating", {31'd0, so0}, 32'h1);
    chk("R5 floating drive flag", {31'd0, drv0}, 32'h0);
    step(1'b1, 1'b0, 1'b0, 1'b0);

    // R3: asynchronous clear, checked without any clock edge
    @(negedge clk);
    clear_n = 1'b0;
    #1;
    chk("R3 ser_out under clear", {31'd0, so0}, 32'h0);
    chk("R3 storage kept under clear", {24'd0, out0}, 32'h71);
    step(1'b1, 1'b1, 1'b0, 1'b0);  // shift ignored during clear
    chk("R3 shift ignored ser_out", {31'd0, so0}, 32'h0);
    clear_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0);  // release a full cycle before next edge
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 cleared shift stage stored", {24'd0, out0}, 32'h00);

    // R8: two chained blocks, 16 bits MSB first
    begin
      logic [15:0] w;
      w = 16'hA5C3;
      for (int i = 15; i >= 0; i--) step(w[i], 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R8 first block later byte", {24'd0, out0}, 32'hC3);
      chk("R8 second block earlier byte", {24'd0, out1}, 32'hA5);
      chk("R8 second block cascade", {31'd0, so1}, 32'h1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule